// File: doc/BRIEF.md
# E1 National-Bit Change Interrupt Monitor

This block sits behind an E1 receive framer. It watches the four national-use Sa bits (Sa5, Sa6, Sa7, Sa8) taken from the odd frames of each CRC-4 submultiframe. For every channel it builds a four-bit nibble and compares it with the nibble from the previous submultiframe. It also compares each Sa bit sample with the sample before it, and it counts how many identical Sa6 nibbles arrive in a row. Two pulses from a PRBS checker are also monitored: a single-error pulse, and a count pulse that steps an 8-bit error counter.

Seven event sources feed a sticky pending register. An event can set its pending bit only while its mask bit is 1. A pending bit stays set until the host writes a 1 to that bit position in a clear strobe. The interrupt line is high while any pending bit is set. While it is high, the vector output carries the fixed code used by all sources.

Top module: `sa_mon_top`

## Requirements
- R1: After reset, `irq_pending` is 0, `irq` is 0 and `irq_vector` is 0.
- R2: An event whose mask bit is 0 leaves its pending bit at 0. Pending bit positions are: 0 = Sa5 bit change, 1 = Sa6 nibble change, 2 = eighth identical Sa6 nibble, 3 = any Sa bit change, 4 = any nibble change, 5 = single PRBS error, 6 = PRBS counter wrap.
- R3: On an `sa_valid` sample, if any bit of `sa_bits` differs from the previous valid sample, pending bit 3 is set. The first sample after reset never sets it. `sa_bits` maps bit 0 = Sa5, 1 = Sa6, 2 = Sa7, 3 = Sa8.
- R4: Pending bit 0 is set only when `sa_bits[0]` (Sa5) differs from its previous valid sample. A change in the other bits alone does not set it.
- R5: A nibble is complete when exactly four `sa_valid` samples arrive between two `smf_strobe` pulses. When a complete nibble differs from the previous complete nibble in any channel, pending bit 4 is set at the closing strobe. An incomplete nibble is discarded and is not compared.
- R6: Pending bit 1 is set when the completed Sa6 nibble (channel bit 1) differs from the previous one. A change only in the other channels does not set it.
- R7: The repeat run restarts at 1 on every Sa6 nibble that differs from the previous one (and on the first nibble after reset). The eighth consecutive identical Sa6 nibble sets pending bit 2. Further identical nibbles in the same run do not set it again.
- R8: A `prbs_err` pulse sets pending bit 5.
- R9: `prbs_tick` steps an 8-bit counter that starts at 0 after reset. The 256th tick wraps it from FFh to 00h and sets pending bit 6. The first 255 ticks do not set it.
- R10: `irq` is 1 exactly when any pending bit is 1. `irq_vector` is 8'h02 while `irq` is 1 and 8'h00 otherwise.
- R11: A pending bit stays set until `clr_wr` is pulsed with a 1 in that position of `clr_bits`. Other bits are untouched by the clear. A new event in the same cycle as its clear leaves the bit set.
- R12: An `sa_valid` sample in the same cycle as `smf_strobe` is the first bit of the next nibble and does not count towards the nibble being closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sa_valid | input | 1 | Sa bit sample strobe (one odd frame) |
| sa_bits | input | 4 | Sa5..Sa8 sample values, bit 0 = Sa5 |
| smf_strobe | input | 1 | Submultiframe boundary pulse |
| prbs_err | input | 1 | Single PRBS detection error pulse |
| prbs_tick | input | 1 | PRBS error counter step pulse |
| irq_mask | input | 7 | Per-source enable, 1 = enabled |
| clr_wr | input | 1 | Clear write strobe |
| clr_bits | input | 7 | Pending bits to clear (1 = clear) |
| irq | output | 1 | Interrupt request |
| irq_vector | output | 8 | Interrupt vector code |
| irq_pending | output | 7 | Sticky pending status |

## Verification
A host clear and a fresh event on the same pending bit can arrive in the same clock. The bench provokes this by pulsing `prbs_err` together with a `clr_wr` that targets bit 5 while that bit is already set. The outcome is judged by the bit still being set, and by a later clear alone removing it while bit 6 stays set. A second coincidence, a Sa sample landing on the submultiframe boundary, is judged by where the resulting nibble-change event falls. The event must be absent at that boundary and present at the following one.

// File: rtl/sa_mon_pkg.sv
package sa_mon_pkg;
    localparam int NUM_SRC      = 7;
    localparam int SRC_SA5_BIT  = 0;
    localparam int SRC_SA6_NIB  = 1;
    localparam int SRC_SA6_REP  = 2;
    localparam int SRC_ANY_BIT  = 3;
    localparam int SRC_ANY_NIB  = 4;
    localparam int SRC_PRBS_ERR = 5;
    localparam int SRC_PRBS_OVF = 6;
    localparam int CH_SA5       = 0;
    localparam int CH_SA6       = 1;

    typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/sa_bit_tracker.sv
module sa_bit_tracker #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sa_valid,
    input  logic [NUM_CH-1:0] sa_bits,
    output logic [NUM_CH-1:0] ch_chg
);
    typedef struct packed {
        logic [NUM_CH-1:0] last;
        logic              have;
    } bit_state_t;

    bit_state_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        ch_chg = '0;
        if (sa_valid) begin
            if (s_q.have) begin
                ch_chg = sa_bits ^ s_q.last;
            end
            s_d.last = sa_bits;
            s_d.have = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/sa_nibble_tracker.sv
module sa_nibble_tracker #(
    parameter int NUM_CH  = 4,
    parameter int NIB_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sa_valid,
    input  logic [NUM_CH-1:0] sa_bits,
    input  logic              smf_strobe,
    output logic              nib_done,
    output logic              nib_cmp,
    output logic [NUM_CH-1:0] nib_chg
);
    localparam int CW = $clog2(NIB_LEN + 2);

    typedef struct packed {
        logic [NUM_CH-1:0][NIB_LEN-1:0] shift;
        logic [NUM_CH-1:0][NIB_LEN-1:0] prev;
        logic [CW-1:0]                  cnt;
        logic                           have_prev;
    } nib_state_t;

    nib_state_t        s_d, s_q;
    logic              close;
    logic [NUM_CH-1:0] differ;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_cmp
        assign differ[c] = (s_q.shift[c] != s_q.prev[c]);
    end

    assign close    = smf_strobe && (s_q.cnt == CW'(NIB_LEN));
    assign nib_done = close;
    assign nib_cmp  = close && s_q.have_prev;
    assign nib_chg  = nib_cmp ? differ : '0;

    always_comb begin
        s_d = s_q;
        if (smf_strobe) begin
            if (close) begin
                s_d.prev      = s_q.shift;
                s_d.have_prev = 1'b1;
            end
            // a sample on the boundary opens the next nibble
            s_d.cnt = sa_valid ? CW'(1) : '0;
        end else if (sa_valid && (s_q.cnt <= CW'(NIB_LEN))) begin
            s_d.cnt = s_q.cnt + CW'(1);
        end
        if (sa_valid) begin
            for (int c = 0; c < NUM_CH; c++) begin
                s_d.shift[c] = {s_q.shift[c][NIB_LEN-2:0], sa_bits[c]};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/sa_repeat_counter.sv
module sa_repeat_counter #(
    parameter int TARGET = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic nib_done,
    input  logic nib_same,
    output logic hit
);
    localparam int RW = $clog2(TARGET + 1);

    typedef struct packed {
        logic [RW-1:0] cnt;
    } rep_state_t;

    rep_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        hit = 1'b0;
        if (nib_done) begin
            if (nib_same) begin
                if (s_q.cnt < RW'(TARGET)) begin
                    s_d.cnt = s_q.cnt + RW'(1);
                    hit     = (s_q.cnt == RW'(TARGET - 1));
                end
            end else begin
                s_d.cnt = RW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/prbs_wrap_counter.sv
module prbs_wrap_counter #(
    parameter int CNT_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic wrap
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        wrap = tick && (s_q.cnt == '1);
        if (tick) begin
            s_d.cnt = s_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/sa_mon_top.sv
module sa_mon_top
    import sa_mon_pkg::*;
#(
    parameter int NUM_CH        = 4,
    parameter int NIB_LEN       = 4,
    parameter int REPEAT_TARGET = 8,
    parameter int PRBS_W        = 8,
    parameter int VEC_W         = 8,
    parameter int VEC_CODE      = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sa_valid,
    input  logic [NUM_CH-1:0]  sa_bits,
    input  logic               smf_strobe,
    input  logic               prbs_err,
    input  logic               prbs_tick,
    input  logic [NUM_SRC-1:0] irq_mask,
    input  logic               clr_wr,
    input  logic [NUM_SRC-1:0] clr_bits,
    output logic               irq,
    output logic [VEC_W-1:0]   irq_vector,
    output logic [NUM_SRC-1:0] irq_pending
);
    typedef struct packed {
        src_vec_t pend;
    } top_state_t;

    top_state_t        s_d, s_q;
    logic [NUM_CH-1:0] bit_chg;
    logic [NUM_CH-1:0] nib_chg;
    logic              nib_done, nib_cmp, rep_hit, prbs_wrap;
    src_vec_t          events, clr_vec;

    sa_bit_tracker #(.NUM_CH(NUM_CH)) u_bits (
        .clk      (clk),
        .rst_n    (rst_n),
        .sa_valid (sa_valid),
        .sa_bits  (sa_bits),
        .ch_chg   (bit_chg)
    );

    sa_nibble_tracker #(.NUM_CH(NUM_CH), .NIB_LEN(NIB_LEN)) u_nib (
        .clk        (clk),
        .rst_n      (rst_n),
        .sa_valid   (sa_valid),
        .sa_bits    (sa_bits),
        .smf_strobe (smf_strobe),
        .nib_done   (nib_done),
        .nib_cmp    (nib_cmp),
        .nib_chg    (nib_chg)
    );

    sa_repeat_counter #(.TARGET(REPEAT_TARGET)) u_rep (
        .clk      (clk),
        .rst_n    (rst_n),
        .nib_done (nib_done),
        .nib_same (nib_cmp && !nib_chg[CH_SA6]),
        .hit      (rep_hit)
    );

    prbs_wrap_counter #(.CNT_W(PRBS_W)) u_prbs (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (prbs_tick),
        .wrap  (prbs_wrap)
    );

    always_comb begin
        events               = '0;
        events[SRC_SA5_BIT]  = bit_chg[CH_SA5];
        events[SRC_ANY_BIT]  = |bit_chg;
        events[SRC_SA6_NIB]  = nib_chg[CH_SA6];
        events[SRC_ANY_NIB]  = |nib_chg;
        events[SRC_SA6_REP]  = rep_hit;
        events[SRC_PRBS_ERR] = prbs_err;
        events[SRC_PRBS_OVF] = prbs_wrap;
        clr_vec              = clr_wr ? clr_bits : '0;
        s_d                  = s_q;
        // set has priority over a simultaneous clear
        s_d.pend             = (s_q.pend & ~clr_vec) | (events & irq_mask);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign irq_pending = s_q.pend;
    assign irq         = |s_q.pend;
    assign irq_vector  = irq ? VEC_W'(VEC_CODE) : '0;
endmodule

// File: rtl/sa_mon_checker.sv
module sa_mon_checker
    import sa_mon_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               prbs_err,
    input logic [NUM_SRC-1:0] irq_mask,
    input logic               clr_wr,
    input logic [NUM_SRC-1:0] clr_bits,
    input logic               irq,
    input logic [VEC_W-1:0]   irq_vector,
    input logic [NUM_SRC-1:0] irq_pending
);
    for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
        AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
            (!irq_pending[k] && !irq_mask[k]) |=> !irq_pending[k]); // R2
        AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_pending[k] && !(clr_wr && clr_bits[k])) |=> irq_pending[k]); // R11
    end

    AST_PRBS_ERR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (prbs_err && irq_mask[SRC_PRBS_ERR]) |=> irq_pending[SRC_PRBS_ERR]); // R8
    AST_VECTOR_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_vector == VEC_W'(2))); // R10
    AST_VECTOR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> (irq_vector == '0)); // R10
    AST_SA5_WITH_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_pending[SRC_SA5_BIT]) && $past(irq_mask[SRC_ANY_BIT]))
            |-> irq_pending[SRC_ANY_BIT]); // R4
    AST_SA6_WITH_NIB: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_pending[SRC_SA6_NIB]) && $past(irq_mask[SRC_ANY_NIB]))
            |-> irq_pending[SRC_ANY_NIB]); // R6
endmodule

bind sa_mon_top sa_mon_checker #(.VEC_W(VEC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .prbs_err    (prbs_err),
    .irq_mask    (irq_mask),
    .clr_wr      (clr_wr),
    .clr_bits    (clr_bits),
    .irq         (irq),
    .irq_vector  (irq_vector),
    .irq_pending (irq_pending)
);

// File: tb/sim_sa_mon_top.sv
module sim_sa_mon_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sa_valid = 1'b0;
    logic [3:0] sa_bits = '0;
    logic       smf_strobe = 1'b0;
    logic       prbs_err = 1'b0;
    logic       prbs_tick = 1'b0;
    logic [6:0] irq_mask = 7'h7F;
    logic       clr_wr = 1'b0;
    logic [6:0] clr_bits = '0;
    logic       irq;
    logic [7:0] irq_vector;
    logic [6:0] irq_pending;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sa_mon_top u0 (
        .clk(clk), .rst_n(rst_n), .sa_valid(sa_valid), .sa_bits(sa_bits),
        .smf_strobe(smf_strobe), .prbs_err(prbs_err), .prbs_tick(prbs_tick),
        .irq_mask(irq_mask), .clr_wr(clr_wr), .clr_bits(clr_bits),
        .irq(irq), .irq_vector(irq_vector), .irq_pending(irq_pending)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic frame(input logic [3:0] b);
        sa_valid = 1'b1; sa_bits = b;
        @(negedge clk);
        sa_valid = 1'b0;
    endtask

    task automatic boundary();
        smf_strobe = 1'b1;
        @(negedge clk);
        smf_strobe = 1'b0;
    endtask

    task automatic nibble(input logic [3:0] b);
        for (int i = 0; i < 4; i++) frame(b);
        boundary();
    endtask

    task automatic clear(input logic [6:0] m);
        clr_wr = 1'b1; clr_bits = m;
        @(negedge clk);
        clr_wr = 1'b0; clr_bits = '0;
    endtask

    task automatic t_reset();
        chk("R1 pending", int'(irq_pending), 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 vector", int'(irq_vector), 0);
    endtask

    task automatic t_bit_change();
        frame(4'b0000);
        chk("R3 first sample silent", int'(irq_pending), 0);
        frame(4'b0100);
        chk("R3 any-bit change", int'(irq_pending[3]), 1);
        chk("R4 Sa5 unchanged", int'(irq_pending[0]), 0);
        clear(7'h7F);
        frame(4'b0101);
        chk("R4 Sa5 change", int'(irq_pending[0]), 1);
        chk("R3 with Sa5", int'(irq_pending[3]), 1);
        chk("R10 irq", int'(irq), 1);
        chk("R10 vector", int'(irq_vector), 2);
    endtask

    task automatic t_nibble();
        boundary();                  // discards partial nibble
        nibble(4'b0000);             // first complete nibble, stored
        clear(7'h7F);
        nibble(4'b0000);
        chk("R5 same nibble", int'(irq_pending[4]), 0);
        chk("R6 same nibble", int'(irq_pending[1]), 0);
        frame(4'b0000); frame(4'b0100); frame(4'b0000); frame(4'b0000);
        boundary();
        chk("R5 Sa7 nibble change", int'(irq_pending[4]), 1);
        chk("R6 Sa6 untouched", int'(irq_pending[1]), 0);
        clear(7'h7F);
        frame(4'b0000); frame(4'b0000); frame(4'b0010); frame(4'b0000);
        boundary();
        chk("R6 Sa6 nibble change", int'(irq_pending[1]), 1);
        chk("R5 with Sa6", int'(irq_pending[4]), 1);
        clear(7'h7F);
        frame(4'b1111); frame(4'b1111); frame(4'b1111);
        boundary();
        chk("R5 incomplete discarded", int'(irq_pending[4]), 0);
    endtask

    task automatic t_repeat();
        clear(7'h7F);
        for (int n = 0; n < 7; n++) nibble(4'b0010);
        chk("R7 seventh no fire", int'(irq_pending[2]), 0);
        nibble(4'b0010);
        chk("R7 eighth fires", int'(irq_pending[2]), 1);
        clear(7'h04);
        nibble(4'b0010);
        chk("R7 ninth silent", int'(irq_pending[2]), 0);
        for (int n = 0; n < 7; n++) nibble(4'b0000);
        chk("R7 restart seventh", int'(irq_pending[2]), 0);
        nibble(4'b0000);
        chk("R7 restart eighth", int'(irq_pending[2]), 1);
    endtask

    task automatic t_coincide();
        boundary();
        clear(7'h7F);
        frame(4'b1111); frame(4'b1111); frame(4'b1111);
        sa_valid = 1'b1; sa_bits = 4'b1111; smf_strobe = 1'b1;
        @(negedge clk);
        sa_valid = 1'b0; smf_strobe = 1'b0;
        chk("R12 boundary sample not in old nibble", int'(irq_pending[4]), 0);
        frame(4'b1111); frame(4'b1111); frame(4'b1111);
        boundary();
        chk("R12 boundary sample opens new nibble", int'(irq_pending[4]), 1);
    endtask

    task automatic t_mask();
        irq_mask = 7'h00;
        clear(7'h7F);
        sa_valid = 1'b1; sa_bits = 4'b0011; prbs_err = 1'b1;
        @(negedge clk);
        sa_valid = 1'b0; prbs_err = 1'b0;
        chk("R2 masked pending", int'(irq_pending), 0);
        chk("R2 masked irq", int'(irq), 0);
        irq_mask = 7'h7F;
    endtask

    task automatic t_prbs();
        clear(7'h7F);
        prbs_err = 1'b1; @(negedge clk); prbs_err = 1'b0;
        chk("R8 error sets", int'(irq_pending[5]), 1);
        clear(7'h7F);
        prbs_tick = 1'b1;
        repeat (255) @(negedge clk);
        prbs_tick = 1'b0;
        chk("R9 no wrap at 255", int'(irq_pending[6]), 0);
        prbs_tick = 1'b1; @(negedge clk); prbs_tick = 1'b0;
        chk("R9 wrap at 256", int'(irq_pending[6]), 1);
    endtask

    task automatic t_race();
        prbs_err = 1'b1; @(negedge clk); prbs_err = 1'b0;
        prbs_err = 1'b1; clr_wr = 1'b1; clr_bits = 7'h20;
        @(negedge clk);
        prbs_err = 1'b0; clr_wr = 1'b0; clr_bits = '0;
        chk("R11 set beats clear", int'(irq_pending[5]), 1);
        clear(7'h20);
        chk("R11 clear removes", int'(irq_pending[5]), 0);
        chk("R11 other bit sticky", int'(irq_pending[6]), 1);
        chk("R10 irq still high", int'(irq), 1);
        clear(7'h7F);
        chk("R10 irq low", int'(irq), 0);
        chk("R10 vector zero", int'(irq_vector), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bit_change();
        t_nibble();
        t_repeat();
        t_coincide();
        t_mask();
        t_prbs();
        t_race();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule